// File: doc/BRIEF.md
# Reconfigurable 32-bit Cipher Execution Lane

This block is one execution lane of a parallel cipher processor. Each issued operation carries three 32-bit words: two data operands, `opnd_a` and `opnd_b`, which come from general registers, and a key word `opnd_k`, which comes from a key register. A 3-bit selector picks one of the lane's operation modules. An 8-bit function field picks the variant inside that module. The lane returns one 32-bit word exactly one cycle after the operation is issued.

Two flags fold the key word into an operation at no extra cost. `key_pre` replaces `opnd_a` with `opnd_a ^ opnd_k` before the operation. `key_post` XORs the key into the result after the operation. Either flag, or both, may be set, and the latency stays at one cycle.

Some tables are static for a given algorithm: a 256-entry byte substitution table and the GF(2^8) reduction polynomial. Both are written through a small configuration port between runs, so operations do not carry them.

Top module: `crypto_lane`

## Requirements
- R1: After reset, `out_valid` is 0 and `result` is 0. The substitution table holds the identity (entry i = i). The field polynomial is 0x1B.
- R2: `out_valid` equals `in_valid` of the previous cycle. `result` changes only one cycle after a cycle with `in_valid` high, and holds its value otherwise.
- R3: Selector 0 (substitute) replaces each of the four bytes of operand A through the substitution table.
- R4: Selector 1 (add/sub) gives A+B mod 2^32 when func[0]=0, and A-B mod 2^32 when func[0]=1.
- R5: Selector 2 (multiply) with func[0]=0 gives the low 32 bits of A*B. With func[0]=1 it multiplies A[15:0] by B[15:0] modulo 65537. In that mode an input of 0 stands for 65536, a product of 65536 is returned as 0, and result[31:16] is 0.
- R6: Selector 3 (shift) shifts A by B[4:0] bits. The function bits func[1:0] choose the variant: 0 = left shift, 1 = logical right shift, 2 = rotate left, 3 = rotate right.
- R7: Selector 4 (field multiply) multiplies each byte of A by the byte of B in the same position, in GF(2^8), reduced by x^8 plus the 8-bit polynomial register.
- R8: Selector 5 (two-input logic) computes a result chosen by func[1:0]: 0 = A AND B, 1 = A OR B, 2 = A XOR B, 3 = NOT A.
- R9: Selector 6 (three-input logic) sets result bit i to func[{A[i],B[i],K[i]}], so the function field is the truth table of any 3-input function.
- R10: When `key_pre` is set, A is replaced by A^K before the operation. When `key_post` is set, the result is XORed with K. Both flags together apply both steps. Every combination keeps the one-cycle latency.
- R11: Selector 7 (move) returns A.
- R12: A configuration write with `cfg_poly`=0 sets table entry `cfg_addr` to `cfg_data`. With `cfg_poly`=1 it sets the polynomial register. An operation issued in the same cycle as a write sees the old contents. Operations issued later see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op_sel | input | 3 | Operation module selector |
| op_func | input | 8 | Variant field or truth table |
| key_pre | input | 1 | XOR key into A before the operation |
| key_post | input | 1 | XOR key into the result |
| opnd_a | input | 32 | First data operand |
| opnd_b | input | 32 | Second data operand |
| opnd_k | input | 32 | Key operand |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_poly | input | 1 | Write targets polynomial (1) or table (0) |
| cfg_addr | input | 8 | Table entry index |
| cfg_data | input | 8 | Configuration data byte |
| out_valid | output | 1 | Result is new this cycle |
| result | output | 32 | Registered operation result |

## Verification
The assertions expect reset to be held at the start of the run. They expect the operand, selector and flag inputs to be known whenever `in_valid` is high. Under that condition they check the valid timing, the holding of the result while idle, the subtract identity and the three-input truth-table selection.

The stimulus changes inputs only on the falling clock edge. It leaves `in_valid` and `cfg_we` low except during a deliberate issue or write. It drives every data input to a defined value from time zero.

// File: rtl/crypto_lane.sv
module crypto_lane #(
  parameter int DW  = 32,
  parameter int BW  = 8,
  parameter logic [7:0] POLY_RST = 8'h1B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op_sel,
  input  logic [7:0]    op_func,
  input  logic          key_pre,
  input  logic          key_post,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] opnd_k,
  input  logic          cfg_we,
  input  logic          cfg_poly,
  input  logic [BW-1:0] cfg_addr,
  input  logic [BW-1:0] cfg_data,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  localparam int NB   = DW / BW;
  localparam int TBL  = 1 << BW;
  localparam int SHW  = $clog2(DW);
  localparam int HW   = DW / 2;

  localparam logic [2:0] OP_SUB  = 3'd0;
  localparam logic [2:0] OP_ADD  = 3'd1;
  localparam logic [2:0] OP_MUL  = 3'd2;
  localparam logic [2:0] OP_SHF  = 3'd3;
  localparam logic [2:0] OP_GF   = 3'd4;
  localparam logic [2:0] OP_LOG2 = 3'd5;
  localparam logic [2:0] OP_LOG3 = 3'd6;
  localparam logic [2:0] OP_MOV  = 3'd7;

  logic [BW-1:0] sbox [TBL];
  logic [BW-1:0] poly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL; i++) sbox[i] <= BW'(i);
      poly <= POLY_RST;
    end else if (cfg_we) begin
      if (cfg_poly) poly <= cfg_data;
      else sbox[cfg_addr] <= cfg_data;
    end
  end

  function automatic logic [BW-1:0] gf_mul(input logic [BW-1:0] x, input logic [BW-1:0] y,
                                           input logic [BW-1:0] p);
    logic [BW-1:0] acc, t;
    acc = '0;
    t   = x;
    for (int i = 0; i < BW; i++) begin
      if (y[i]) acc = acc ^ t;
      t = t[BW-1] ? ({t[BW-2:0], 1'b0} ^ p) : {t[BW-2:0], 1'b0};
    end
    return acc;
  endfunction

  wire [DW-1:0] a = key_pre ? (opnd_a ^ opnd_k) : opnd_a;
  wire [DW-1:0] b = opnd_b;
  wire [DW-1:0] k = opnd_k;

  logic [DW-1:0] r_sub, r_gf, r_log3;
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      r_sub[i*BW +: BW] = sbox[a[i*BW +: BW]];
      r_gf[i*BW +: BW]  = gf_mul(a[i*BW +: BW], b[i*BW +: BW], poly);
    end
    for (int i = 0; i < DW; i++) r_log3[i] = op_func[{a[i], b[i], k[i]}];
  end

  wire [DW-1:0] r_add = op_func[0] ? (a - b) : (a + b);

  wire [HW:0]       mx = (a[HW-1:0] == '0) ? {1'b1, {HW{1'b0}}} : {1'b0, a[HW-1:0]};
  wire [HW:0]       my = (b[HW-1:0] == '0) ? {1'b1, {HW{1'b0}}} : {1'b0, b[HW-1:0]};
  wire [2*HW+1:0]   mprod = {{(HW+1){1'b0}}, mx} * {{(HW+1){1'b0}}, my};
  wire [2*HW+1:0]   mrem  = mprod % {{HW{1'b0}}, 1'b1, {(HW-1){1'b0}}, 1'b1};
  wire [2*DW-1:0]   wprod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
  wire [DW-1:0] r_mul = op_func[0] ? {{HW{1'b0}}, mrem[HW-1:0]} : wprod[DW-1:0];

  wire [SHW-1:0] amt  = b[SHW-1:0];
  wire [SHW:0]   ramt = (SHW+1)'(DW) - {1'b0, amt};
  logic [DW-1:0] r_shf;
  always_comb begin
    case (op_func[1:0])
      2'd0:    r_shf = a << amt;
      2'd1:    r_shf = a >> amt;
      2'd2:    r_shf = (a << amt) | (a >> ramt);
      default: r_shf = (a >> amt) | (a << ramt);
    endcase
  end

  logic [DW-1:0] r_log2;
  always_comb begin
    case (op_func[1:0])
      2'd0:    r_log2 = a & b;
      2'd1:    r_log2 = a | b;
      2'd2:    r_log2 = a ^ b;
      default: r_log2 = ~a;
    endcase
  end

  logic [DW-1:0] core;
  always_comb begin
    case (op_sel)
      OP_SUB:  core = r_sub;
      OP_ADD:  core = r_add;
      OP_MUL:  core = r_mul;
      OP_SHF:  core = r_shf;
      OP_GF:   core = r_gf;
      OP_LOG2: core = r_log2;
      OP_LOG3: core = r_log3;
      default: core = a;
    endcase
  end

  wire [DW-1:0] fin = key_post ? (core ^ k) : core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= fin;
    end
  end

  a_r2_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r4_sub_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_ADD && op_func[0] && !key_pre && !key_post)
      |=> (DW'(result + $past(opnd_b)) == $past(opnd_a)));
  a_r9_tt_select_a: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_LOG3 && op_func == 8'hF0 && !key_pre && !key_post)
      |=> (result == $past(opnd_a)));
endmodule

// File: tb/sim_crypto_lane.sv
module sim_crypto_lane;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [7:0]  op_func = '0;
  logic        key_pre = 1'b0, key_post = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, opnd_k = '0;
  logic        cfg_we = 1'b0, cfg_poly = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_data = '0;
  logic        out_valid;
  logic [31:0] result;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  crypto_lane u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .op_func(op_func),
    .key_pre(key_pre), .key_post(key_post), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .opnd_k(opnd_k), .cfg_we(cfg_we), .cfg_poly(cfg_poly), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .out_valid(out_valid), .result(result)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] v, input logic [7:0] p);
    return v[7] ? ((v << 1) ^ p) : (v << 1);
  endfunction

  function automatic logic [7:0] gf_ref(input logic [7:0] x, input logic [7:0] y,
                                        input logic [7:0] p);
    logic [7:0] pw [8];
    logic [7:0] s;
    pw[0] = x;
    for (int i = 1; i < 8; i++) pw[i] = xt(pw[i-1], p);
    s = 8'h00;
    for (int i = 7; i >= 0; i--) if (y[i]) s ^= pw[i];
    return s;
  endfunction

  function automatic logic [31:0] gf_word(input logic [31:0] x, input logic [31:0] y,
                                          input logic [7:0] p);
    return {gf_ref(x[31:24], y[31:24], p), gf_ref(x[23:16], y[23:16], p),
            gf_ref(x[15:8], y[15:8], p), gf_ref(x[7:0], y[7:0], p)};
  endfunction

  task automatic issue(input logic [2:0] s, input logic [7:0] f, input logic pre,
                       input logic post, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] k, input logic [31:0] exp, input string tag);
    @(negedge clk);
    op_sel = s; op_func = f; key_pre = pre; key_post = post;
    opnd_a = a; opnd_b = b; opnd_k = k; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk(tag, result, exp);
  endtask

  task automatic cfg_write(input logic poly, input logic [7:0] ad, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_poly = poly; cfg_addr = ad; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 result", result, 32'd0);
    issue(3'd0, 8'h00, 0, 0, 32'h11223344, 0, 0, 32'h11223344, "R1 identity table");
    issue(3'd4, 8'h00, 0, 0, 32'h80808080, 32'h02020202, 0, 32'h1B1B1B1B, "R1 poly 1B");
  endtask

  task automatic t_idle_hold;
    logic [31:0] last;
    issue(3'd7, 8'h00, 0, 0, 32'hCAFEF00D, 0, 0, 32'hCAFEF00D, "R11 move");
    last = result;
    @(negedge clk);
    opnd_a = 32'h12345678;
    @(negedge clk);
    chk("R2 idle valid low", {31'd0, out_valid}, 32'd0);
    chk("R2 idle hold", result, last);
  endtask

  task automatic t_sbox;
    cfg_write(0, 8'h44, 8'h9C);
    cfg_write(0, 8'h11, 8'h01);
    issue(3'd0, 8'h00, 0, 0, 32'h11223344, 0, 0, 32'h0122339C, "R3 substitute");
    @(negedge clk);
    cfg_we = 1'b1; cfg_poly = 1'b0; cfg_addr = 8'h22; cfg_data = 8'h77;
    op_sel = 3'd0; opnd_a = 32'h22222222; key_pre = 0; key_post = 0; in_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R12 same-cycle write sees old", result, 32'h22222222);
    issue(3'd0, 8'h00, 0, 0, 32'h22222222, 0, 0, 32'h77777777, "R12 later op sees new");
  endtask

  task automatic t_addsub;
    issue(3'd1, 8'h00, 0, 0, 32'hFFFFFFFF, 32'd2, 0, 32'd1, "R4 add wrap");
    issue(3'd1, 8'h01, 0, 0, 32'd1, 32'd2, 0, 32'hFFFFFFFF, "R4 sub wrap");
  endtask

  task automatic t_mul;
    issue(3'd2, 8'h00, 0, 0, 32'h00010001, 32'h00010001, 0, 32'h00020001, "R5 low product");
    issue(3'd2, 8'h00, 0, 0, 32'h12345678, 32'h10, 0, 32'h23456780, "R5 low product 2");
    issue(3'd2, 8'h01, 0, 0, 32'h0, 32'h0, 0, 32'd1, "R5 mod 0*0");
    issue(3'd2, 8'h01, 0, 0, 32'h0, 32'd5, 0, 32'h0000FFFC, "R5 mod 0*5");
    issue(3'd2, 8'h01, 0, 0, 32'd2, 32'h8000, 0, 32'h0, "R5 mod result 65536");
    issue(3'd2, 8'h01, 0, 0, 32'hABCD0003, 32'h00070004, 0, 32'd12, "R5 mod high ignored");
  endtask

  task automatic t_shift;
    issue(3'd3, 8'h00, 0, 0, 32'h80000001, 32'd4, 0, 32'h00000010, "R6 shl");
    issue(3'd3, 8'h01, 0, 0, 32'h80000001, 32'd4, 0, 32'h08000000, "R6 shr");
    issue(3'd3, 8'h02, 0, 0, 32'h80000001, 32'd4, 0, 32'h00000018, "R6 rotl");
    issue(3'd3, 8'h03, 0, 0, 32'h80000001, 32'd36, 0, 32'h18000000, "R6 rotr low bits");
    issue(3'd3, 8'h03, 0, 0, 32'h80000001, 32'd0, 0, 32'h80000001, "R6 rotr zero");
  endtask

  task automatic t_gf;
    issue(3'd4, 8'h00, 0, 0, 32'h57010280, 32'h83035703, 0,
          gf_word(32'h57010280, 32'h83035703, 8'h1B), "R7 field multiply");
    chk("R7 known byte", gf_ref(8'h57, 8'h83, 8'h1B), 32'h000000C1);
    cfg_write(1, 8'h00, 8'h1D);
    issue(3'd4, 8'h00, 0, 0, 32'hA5C38001, 32'h3C7F02FF, 0,
          gf_word(32'hA5C38001, 32'h3C7F02FF, 8'h1D), "R7 new polynomial");
    cfg_write(1, 8'h00, 8'h1B);
  endtask

  task automatic t_logic;
    issue(3'd5, 8'h00, 0, 0, 32'hF0F0FF00, 32'hFF00F0F0, 0, 32'hF000F000, "R8 and");
    issue(3'd5, 8'h01, 0, 0, 32'hF0F0FF00, 32'hFF00F0F0, 0, 32'hFFF0FFF0, "R8 or");
    issue(3'd5, 8'h02, 0, 0, 32'hF0F0FF00, 32'hFF00F0F0, 0, 32'h0FF00FF0, "R8 xor");
    issue(3'd5, 8'h03, 0, 0, 32'hF0F0FF00, 32'hFF00F0F0, 0, 32'h0F0F00FF, "R8 not");
    issue(3'd6, 8'hF0, 0, 0, 32'h1234ABCD, 32'h0F0F0F0F, 32'h55AA55AA, 32'h1234ABCD, "R9 select A");
    issue(3'd6, 8'h96, 0, 0, 32'h1234ABCD, 32'h0F0F0F0F, 32'h55AA55AA,
          32'h1234ABCD ^ 32'h0F0F0F0F ^ 32'h55AA55AA, "R9 parity");
    issue(3'd6, 8'hE8, 0, 0, 32'h1234ABCD, 32'h0F0F0F0F, 32'h55AA55AA,
          (32'h1234ABCD & 32'h0F0F0F0F) | (32'h1234ABCD & 32'h55AA55AA) |
          (32'h0F0F0F0F & 32'h55AA55AA), "R9 majority");
  endtask

  task automatic t_keyxor;
    logic [31:0] a, b, k;
    a = 32'h10203040; b = 32'h0A0B0C0D; k = 32'hFF00FF00;
    issue(3'd1, 8'h00, 1, 0, a, b, k, (a ^ k) + b, "R10 pre");
    issue(3'd1, 8'h00, 0, 1, a, b, k, (a + b) ^ k, "R10 post");
    issue(3'd1, 8'h00, 1, 1, a, b, k, ((a ^ k) + b) ^ k, "R10 both");
    issue(3'd4, 8'h00, 0, 1, a, 32'h02030102, k,
          gf_word(a, 32'h02030102, 8'h1B) ^ k, "R10 field multiply then key");
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre();
    rst_n = 1'b1;
    t_reset();
    t_idle_hold();
    t_sbox();
    t_addsub();
    t_mul();
    t_shift();
    t_gf();
    t_logic();
    t_keyxor();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic t_reset_pre;
    chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 result in reset", result, 32'd0);
  endtask
endmodule